// File: doc/BRIEF.md
# Serial Shift Unit with Edge/Bit Counter

This block is a three-wire synchronous serial port built around a byte-wide shift register and a small transfer counter that share one clock event stream. A host bus reads and writes the shift register, the counter and a control register. Each clock event moves the shift register and the counter together. When the counter wraps, a sticky overflow flag is raised, and it can drive an interrupt. Firmware then knows that a byte has been exchanged.

The clock events come from one of three selectable sources: the synchronised serial-clock pin, a timer compare-match pulse, or a software strobe written into the control register. On the pin source the counter advances on both edges of the serial clock, so it counts edges and not bits: a byte exchange takes sixteen edges. A master produces the serial clock by toggling its clock output through a control write, and that output can be looped back to its own clock pin. There is no hardware slave-select. Clock phase follows the two phase choices of serial mode 0 and mode 1.

Top module: `sshift_unit`

## Requirements
- R1: Address 0 reads the shift register. A host write to address 0 loads it, takes priority over any shift in the same cycle, and sets dataOut to the written bit 7 on the next cycle.
- R2: Address 1 reads {3'b000, flag, counter[3:0]}. A write to address 1 loads counter[3:0] from write data bits 3:0. The counter changes only on a load or a clock event.
- R3: Each clock event advances the shift register and the counter together. The timer and software sources give one event per pulse. The pin source gives one count on every rising and every falling edge of the pin, so sixteen edges starting from 0 return the counter to 0.
- R4: A count taken while the counter is 15 wraps it to 0 and sets the flag. The flag reads at address 1 bit 4 and at address 3 bit 0. irq equals flag AND control bit 3.
- R5: The flag stays set until the host writes address 3 with bit 0 = 1. Clearing the flag leaves the counter value unchanged.
- R6: Control bits 1:0 select the source: 0 none, 1 pin, 2 timer, 3 software. Control writes with bit 4 = 1 and bits 1:0 = 3 make one software event. Events from unselected sources change neither the counter nor the shift register.
- R7: Control bit 2 = 0 (mode 0) samples dataIn on the rising pin edge and updates dataOut on the falling edge. Bit 2 = 1 (mode 1) samples on the falling edge and updates dataOut on the rising edge. Sampling shifts dataIn into bit 0, MSB first.
- R8: dataOut shows bit 7 of the shift register. It changes only on an output-update edge, a timer or software event, or a host data write.
- R9: A control write with bit 5 = 1 inverts sclkOut. With sclkOut looped to sclkIn, eight toggle pairs exchange a byte with the partner.
- R10: A timer or software event shifts dataIn straight into bit 0, and dataOut takes the new bit 7 on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Host write strobe |
| busAddr | input | 2 | Host register address |
| busWrData | input | 8 | Host write data |
| busRdData | output | 8 | Host read data (combinational on busAddr) |
| sclkIn | input | 1 | Serial clock pin input |
| sclkOut | output | 1 | Serial clock driven by the master toggle |
| timerTick | input | 1 | Timer compare-match pulse |
| dataIn | input | 1 | Serial data in |
| dataOut | output | 1 | Serial data out |
| irq | output | 1 | Overflow interrupt |

## Verification
Host writes and timer or software events change the registers at the clock edge that ends the write or pulse cycle. The bench reads them back on the following low phase. A pin edge takes effect on the third rising clock edge after the pin changes: two synchroniser stages, then the edge-detect register. The bench therefore waits six cycles after every pin change before it checks dataOut or drives the next data bit. Reads are sampled one nanosecond after the falling edge, and the combinational read path has settled by then.

// File: rtl/sshift_pkg.sv
package sshift_pkg;
  localparam int DATA_W      = 8;
  localparam int CNT_W       = 4;
  localparam int CTRL_W      = 6;
  localparam int SRC_LO      = 0;
  localparam int PHASE_BIT   = 2;
  localparam int IRQEN_BIT   = 3;
  localparam int TICK_BIT    = 4;
  localparam int TOGGLE_BIT  = 5;

  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_FLAG = 2'd3
  } addr_e;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'd0,
    SRC_PIN   = 2'd1,
    SRC_TIMER = 2'd2,
    SRC_SOFT  = 2'd3
  } src_e;

  typedef struct packed {
    logic loadData;
    logic loadCnt;
    logic clrFlag;
    logic shiftIn;
    logic outEdge;
    logic tick;
    logic count;
  } stb_t;
endpackage

// File: rtl/sshift_ctrl.sv
module sshift_ctrl
  import sshift_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic [1:0]        busAddr,
  input  logic [CTRL_W-1:0] wrCtrlData,
  input  logic              pinClk,
  input  logic              timerTick,
  output stb_t              stb,
  output src_e              srcQ,
  output logic              phaseQ,
  output logic              irqEnQ,
  output logic              sclkQ
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic pinPrevQ, pinLvl, pinRise, pinFall, pinEn;
  logic wrCtrl, sampleEdge, updEdge, softTick, timerEv;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rst_n) syncQ <= '0;
        else        syncQ <= pinClk;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rst_n) syncQ <= '0;
        else        syncQ <= {syncQ[SYNC_STAGES-2:0], pinClk};
      end
    end
  endgenerate

  assign pinLvl  = syncQ[SYNC_STAGES-1];
  assign pinRise = pinLvl & ~pinPrevQ;
  assign pinFall = ~pinLvl & pinPrevQ;
  assign wrCtrl  = busWrEn && (busAddr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pinPrevQ <= 1'b0;
      srcQ     <= SRC_OFF;
      phaseQ   <= 1'b0;
      irqEnQ   <= 1'b0;
      sclkQ    <= 1'b0;
    end else begin
      pinPrevQ <= pinLvl;
      if (wrCtrl) begin
        srcQ   <= src_e'(wrCtrlData[SRC_LO+1:SRC_LO]);
        phaseQ <= wrCtrlData[PHASE_BIT];
        irqEnQ <= wrCtrlData[IRQEN_BIT];
        if (wrCtrlData[TOGGLE_BIT]) sclkQ <= ~sclkQ;
      end
    end
  end

  assign pinEn      = (srcQ == SRC_PIN);
  assign sampleEdge = phaseQ ? pinFall : pinRise;
  assign updEdge    = phaseQ ? pinRise : pinFall;
  assign softTick   = wrCtrl && wrCtrlData[TICK_BIT] &&
                      (wrCtrlData[SRC_LO+1:SRC_LO] == SRC_SOFT);
  assign timerEv    = (srcQ == SRC_TIMER) && timerTick;

  always_comb begin
    stb          = '0;
    stb.loadData = busWrEn && (busAddr == ADDR_DATA);
    stb.loadCnt  = busWrEn && (busAddr == ADDR_CNT);
    stb.clrFlag  = busWrEn && (busAddr == ADDR_FLAG) && wrCtrlData[0];
    stb.shiftIn  = pinEn && sampleEdge;
    stb.outEdge  = pinEn && updEdge;
    stb.tick     = softTick || timerEv;
    stb.count    = stb.tick || (pinEn && (pinRise || pinFall));
  end
endmodule

// File: rtl/sshift_datapath.sv
module sshift_datapath
  import sshift_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  stb_t              stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dataIn,
  output logic [DATA_W-1:0] shiftQ,
  output logic [CNT_W-1:0]  cntQ,
  output logic              flagQ,
  output logic              outQ
);
  localparam int MSB = DATA_W - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftQ <= '0;
      outQ   <= 1'b0;
    end else if (stb.loadData) begin
      shiftQ <= wrData;
      outQ   <= wrData[MSB];
    end else if (stb.tick) begin
      shiftQ <= {shiftQ[MSB-1:0], dataIn};
      outQ   <= shiftQ[MSB-1];
    end else begin
      if (stb.shiftIn) shiftQ <= {shiftQ[MSB-1:0], dataIn};
      if (stb.outEdge) outQ   <= shiftQ[MSB];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ  <= '0;
      flagQ <= 1'b0;
    end else begin
      if (stb.loadCnt)    cntQ <= wrData[CNT_W-1:0];
      else if (stb.count) cntQ <= cntQ + 1'b1;
      if (stb.count && !stb.loadCnt && (&cntQ)) flagQ <= 1'b1;
      else if (stb.clrFlag)                      flagQ <= 1'b0;
    end
  end
endmodule

// File: rtl/sshift_unit.sv
module sshift_unit
  import sshift_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              sclkIn,
  output logic              sclkOut,
  input  logic              timerTick,
  input  logic              dataIn,
  output logic              dataOut,
  output logic              irq
);
  stb_t              stb;
  src_e              srcQ;
  logic              phaseQ, irqEnQ, flagQ;
  logic [DATA_W-1:0] shiftQ;
  logic [CNT_W-1:0]  cntQ;

  sshift_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busAddr(busAddr),
    .wrCtrlData(busWrData[CTRL_W-1:0]), .pinClk(sclkIn), .timerTick(timerTick),
    .stb(stb), .srcQ(srcQ), .phaseQ(phaseQ), .irqEnQ(irqEnQ), .sclkQ(sclkOut)
  );

  sshift_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrData(busWrData), .dataIn(dataIn),
    .shiftQ(shiftQ), .cntQ(cntQ), .flagQ(flagQ), .outQ(dataOut)
  );

  assign irq = flagQ & irqEnQ;

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      ADDR_DATA: busRdData = shiftQ;
      ADDR_CNT:  busRdData[CNT_W:0] = {flagQ, cntQ};
      ADDR_CTRL: busRdData[IRQEN_BIT:0] = {irqEnQ, phaseQ, srcQ};
      ADDR_FLAG: busRdData[0] = flagQ;
      default:   busRdData = '0;
    endcase
  end
endmodule

// File: rtl/sshift_unit_chk.sv
module sshift_unit_chk
  import sshift_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input stb_t             stb,
  input logic [CNT_W-1:0] cntQ,
  input logic             flagQ,
  input logic             dataOut,
  input logic             irq
);
  // R8: dataOut moves only on an update edge, an event or a data write
  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.loadData || stb.outEdge || stb.tick) |=> $stable(dataOut));
  // R5: flag is sticky until cleared
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flagQ && !stb.clrFlag) |=> flagQ);
  // R5: clearing the flag keeps the counter value
  a_r5_clear_keeps_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.clrFlag && !stb.count && !stb.loadCnt) |=> $stable(cntQ));
  // R4: a count at the top value wraps to zero and raises the flag
  a_r4_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.count && !stb.loadCnt && (&cntQ)) |=> (flagQ && (cntQ == '0)));
  // R2: counter holds with no load and no event
  a_r2_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.count && !stb.loadCnt) |=> $stable(cntQ));
  // R4: interrupt only with the flag set
  a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flagQ);
  // R7: sample and update edges never coincide
  a_r7_edges_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.shiftIn && stb.outEdge));
endmodule

bind sshift_unit sshift_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stb(stb), .cntQ(cntQ), .flagQ(flagQ),
  .dataOut(dataOut), .irq(irq)
);

// File: tb/sshift_unit_tb.sv
module sshift_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busWrEn = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;
  logic sclkOut, dataOut, irq;
  logic extClk = 1'b0, loopEn = 1'b0, timerTick = 1'b0, dataIn = 1'b0;
  logic sclkIn;
  int nChecks = 0, nFails = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;
  assign sclkIn = loopEn ? sclkOut : extClk;

  sshift_unit u_dut (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .sclkIn(sclkIn),
    .sclkOut(sclkOut), .timerTick(timerTick), .dataIn(dataIn),
    .dataOut(dataOut), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); busAddr = a; #1; v = busRdData;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic pulseTimer();
    @(negedge clk); timerTick = 1'b1;
    @(negedge clk); timerTick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v, d, s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd(2'd0, v); chk("R1 reset data", v, 8'h00);
    rd(2'd1, v); chk("R2 reset cnt", v, 8'h00);
    rd(2'd2, v); chk("R6 reset ctrl", v, 8'h00);
    chk("R4 reset irq", {7'd0, irq}, 8'h00);
    chk("R9 reset sclkOut", {7'd0, sclkOut}, 8'h00);

    // R1 data register sweep
    for (int i = 0; i < 256; i += 17) begin
      wr(2'd0, 8'(i));
      rd(2'd0, v); chk("R1 data rw", v, 8'(i));
      chk("R1 dataOut msb", {7'd0, dataOut}, {7'd0, v[7]});
    end
    // R2 counter register sweep
    for (int i = 0; i < 16; i++) begin
      wr(2'd1, 8'(i));
      rd(2'd1, v); chk("R2 cnt rw", v, 8'(i));
    end

    // R10/R3/R4 software-event exchange over many byte pairs
    for (int k = 0; k < 12; k++) begin
      d = 8'(k * 37 + 5);
      s = 8'(~d ^ 8'(k * 11));
      wr(2'd3, 8'h01);
      wr(2'd0, d);
      wr(2'd1, 8'd8);
      wr(2'd2, 8'h0B);
      for (int i = 0; i < 8; i++) begin
        chk("R10 dataOut before event", {7'd0, dataOut}, {7'd0, d[7-i]});
        dataIn = s[7-i];
        wr(2'd2, 8'h1B);
      end
      rd(2'd0, v); chk("R10 sw exchange data", v, s);
      rd(2'd1, v); chk("R4 sw wrap cnt+flag", v, 8'h10);
      chk("R4 irq enabled", {7'd0, irq}, 8'h01);
      chk("R8 dataOut new msb", {7'd0, dataOut}, {7'd0, s[7]});
    end

    // R5 clear keeps counter
    wr(2'd1, 8'd5);
    rd(2'd3, v); chk("R5 flag still set", v, 8'h01);
    wr(2'd3, 8'h01);
    rd(2'd1, v); chk("R5 clear keeps cnt", v, 8'h05);
    chk("R4 irq low after clear", {7'd0, irq}, 8'h00);
    wr(2'd3, 8'h00);
    rd(2'd1, v); chk("R5 zero write keeps", v, 8'h05);

    // R6 timer source: pin and software ignored
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'd0);
    wr(2'd2, 8'h02);
    extClk = 1'b1; settle(); extClk = 1'b0; settle();
    rd(2'd1, v); chk("R6 pin ignored on timer", v, 8'h00);
    rd(2'd0, v); chk("R6 data untouched", v, 8'hA5);
    dataIn = 1'b1;
    for (int i = 0; i < 3; i++) pulseTimer();
    rd(2'd1, v); chk("R3 timer counts", v, 8'h03);
    rd(2'd0, v); chk("R10 timer shifts", v, 8'h2F);
    // off source ignores timer
    wr(2'd2, 8'h00);
    pulseTimer();
    rd(2'd1, v); chk("R6 off ignores timer", v, 8'h03);
    // pin source ignores timer
    wr(2'd2, 8'h01);
    pulseTimer();
    rd(2'd1, v); chk("R6 pin ignores timer", v, 8'h03);

    // R9/R7 master mode 0 with loopback, 16 edges
    for (int k = 0; k < 4; k++) begin
      d = 8'(8'h3C ^ 8'(k * 73));
      s = 8'(8'hC1 + 8'(k * 29));
      wr(2'd3, 8'h01);
      wr(2'd0, d);
      wr(2'd1, 8'd0);
      wr(2'd2, 8'h09);
      loopEn = 1'b1;
      for (int i = 0; i < 8; i++) begin
        chk("R7 m0 dataOut before rise", {7'd0, dataOut}, {7'd0, d[7-i]});
        dataIn = s[7-i];
        wr(2'd2, 8'h29); settle();
        if (i == 0) chk("R9 sclkOut toggled", {7'd0, sclkOut}, 8'h01);
        wr(2'd2, 8'h29); settle();
      end
      rd(2'd0, v); chk("R9 master exchange", v, s);
      rd(2'd1, v); chk("R3 16 edges wrap", v, 8'h10);
      chk("R4 irq pin mode", {7'd0, irq}, 8'h01);
      loopEn = 1'b0;
    end

    // R7 slave mode 1 with external clock
    for (int k = 0; k < 4; k++) begin
      d = 8'(8'h96 + 8'(k * 51));
      s = 8'(8'h4B ^ 8'(k * 90));
      wr(2'd3, 8'h01);
      wr(2'd0, d);
      wr(2'd1, 8'd0);
      wr(2'd2, 8'h05);
      for (int i = 0; i < 8; i++) begin
        extClk = 1'b1; settle();
        chk("R7 m1 dataOut after rise", {7'd0, dataOut}, {7'd0, d[7-i]});
        if (i == 1) begin
          rd(2'd1, v); chk("R3 both edges counted", v, 8'h03);
        end
        dataIn = s[7-i];
        extClk = 1'b0; settle();
      end
      rd(2'd0, v); chk("R7 m1 exchange", v, s);
      rd(2'd1, v); chk("R4 m1 wrap flag", v, 8'h10);
      chk("R4 irq masked", {7'd0, irq}, 8'h00);
    end

    // R1 write beats shift on same cycle: data write then confirm
    wr(2'd2, 8'h03);
    wr(2'd0, 8'h81);
    chk("R8 dataOut after write", {7'd0, dataOut}, 8'h01);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule